// File: doc/BRIEF.md
# Serial Flash Read Command Front-End

This block is the device-side command front-end for reads from a paged flash array that also has two SRAM buffers. It acts as an SPI mode 0 slave. It samples the serial clock, the active-low chip select and the serial input on a fast system clock. It takes an 8-bit opcode and a 32-bit address word, then counts the dummy clocks that opcode needs. After that it streams bytes out on the serial output, most significant bit first.

While it streams, the block drives a read port toward the array or a buffer. The port carries a source select, a page index and a byte index, and the memory returns one byte combinationally. An internal address sequencer receives the start address and a wrap mode chosen by the opcode. It moves to the next byte each time a new byte is loaded for output. The block only reads: it has no path that writes to a buffer or to the array.

The output enable is kept separate from the data bit, so the pad can be tri-stated whenever no data phase is running.

Top module: `spi_flash_read_fe`

## Requirements
- R1: After reset, and whenever `cs_n` has been high for two clock edges in a row, `so_oe` is low.
- R2: Opcode D2h starts a page read from main memory (`mem_sel` = 0). In the 32-bit address word, sent MSB first, the lowest BYTE_BITS bits are the byte index, the next PAGE_BITS bits are the page, and the bits above them are ignored. The opcode is followed by 24 dummy clocks.
- R3: Opcodes D4h and D6h read buffer 1 (`mem_sel` = 1) and buffer 2 (`mem_sel` = 2). For these, only the lowest BYTE_BITS address bits count, `mem_page` is driven to 0, and 8 dummy clocks follow the address. `mem_sel` holds steady for the whole data phase.
- R4: The opcode given by parameter CAR_OPCODE (default E8h) starts a continuous read of main memory. Its address layout and dummy count are the same as for D2h.
- R5: In a page read, the byte after index PAGE_BYTES-1 is byte 0 of the same page. Otherwise the index rises by one per byte.
- R6: In a continuous read, the byte after index PAGE_BYTES-1 is byte 0 of the next page. The last page is followed by page 0.
- R7: In a buffer read, the byte after index PAGE_BYTES-1 is byte 0 of the same buffer.
- R8: After any other opcode, `so_oe` stays low for every later clock until `cs_n` goes high. The next command after that is decoded normally.
- R9: A rising `cs_n` at any point, including partway through a data byte, drops `so_oe` one clock edge later. The following command starts again from its opcode.
- R10: SI is sampled on rising SCK, and SO changes only after falling SCK. The first data bit (bit 7 of the first byte) appears after the falling SCK that follows the last dummy clock. `so_oe` stays low during the opcode, address and dummy phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the SO pad |
| mem_sel | output | 2 | Read source: 0 main array, 1 buffer 1, 2 buffer 2 |
| mem_page | output | PAGE_BITS | Page index of the current byte |
| mem_byte | output | BYTE_BITS | Byte index within the page or buffer |
| mem_data | input | 8 | Byte returned for the current read address |

## Verification
The SPI pins are registered once, so an SCK edge is acted on at the second clock edge after the pin changes. SO therefore settles two clock edges after a falling SCK, and `so_oe` drops one clock edge after `cs_n` rises. The host model holds each SCK level for four clocks and reads SO at the end of each low phase, after the new bit has had time to settle. It checks `so_oe` two clocks after raising `cs_n`. Expected bytes come from the memory formula and a wrap rule for each mode. These are advanced byte by byte in the bench across every start page and byte of a small configuration.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam logic [7:0] OP_PAGE_RD = 8'hD2;
    localparam logic [7:0] OP_BUF1_RD = 8'hD4;
    localparam logic [7:0] OP_BUF2_RD = 8'hD6;
    localparam logic [4:0] DUMMY_MAIN = 5'd24;
    localparam logic [4:0] DUMMY_BUF  = 5'd8;

    typedef enum logic [2:0] {
        PH_OPC    = 3'd0,
        PH_ADDR   = 3'd1,
        PH_DUMMY  = 3'd2,
        PH_DATA   = 3'd3,
        PH_IGNORE = 3'd4
    } phase_t;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_BUF1 = 2'd1,
        SRC_BUF2 = 2'd2
    } src_t;

    typedef enum logic [1:0] {
        WRAP_PAGE  = 2'd0,
        WRAP_ARRAY = 2'd1,
        WRAP_BUF   = 2'd2
    } wrap_t;

    typedef struct packed {
        logic       valid;
        src_t       src;
        wrap_t      wrap;
        logic [4:0] dummy_bits;
    } cmd_t;

    function automatic cmd_t decode_op(input logic [7:0] op, input logic [7:0] car_op);
        cmd_t d;
        d = '{valid: 1'b0, src: SRC_MAIN, wrap: WRAP_PAGE, dummy_bits: 5'd0};
        if (op == OP_PAGE_RD) begin
            d = '{valid: 1'b1, src: SRC_MAIN, wrap: WRAP_PAGE, dummy_bits: DUMMY_MAIN};
        end else if (op == OP_BUF1_RD) begin
            d = '{valid: 1'b1, src: SRC_BUF1, wrap: WRAP_BUF, dummy_bits: DUMMY_BUF};
        end else if (op == OP_BUF2_RD) begin
            d = '{valid: 1'b1, src: SRC_BUF2, wrap: WRAP_BUF, dummy_bits: DUMMY_BUF};
        end else if (op == car_op) begin
            d = '{valid: 1'b1, src: SRC_MAIN, wrap: WRAP_ARRAY, dummy_bits: DUMMY_MAIN};
        end
        return d;
    endfunction

endpackage

// File: rtl/sfr_cmd_parser.sv
module sfr_cmd_parser
    import sfr_pkg::*;
#(
    parameter int         ADDR_USED  = 25,
    parameter logic [7:0] CAR_OPCODE = 8'hE8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active,
    input  logic                 sck_rise,
    input  logic                 si_bit,
    output phase_t               phase,
    output cmd_t                 cmd,
    output logic [ADDR_USED-1:0] addr_word,
    output logic                 addr_load
);
    localparam int SHW = (ADDR_USED - 1 > 7) ? ADDR_USED - 1 : 7;

    logic [SHW-1:0]       sh;
    logic [5:0]           cnt;
    logic [7:0]           op_now;
    logic [ADDR_USED-1:0] addr_now;
    cmd_t                 dec;

    assign op_now   = {sh[6:0], si_bit};
    assign addr_now = {sh[ADDR_USED-2:0], si_bit};
    assign dec      = decode_op(op_now, CAR_OPCODE);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase     <= PH_OPC;
            cmd       <= '{valid: 1'b0, src: SRC_MAIN, wrap: WRAP_PAGE, dummy_bits: 5'd0};
            sh        <= '0;
            cnt       <= '0;
            addr_word <= '0;
            addr_load <= 1'b0;
        end else begin
            addr_load <= 1'b0;
            if (sck_rise) begin
                case (phase)
                    PH_OPC: begin
                        sh <= {sh[SHW-2:0], si_bit};
                        if (cnt == 6'd7) begin
                            cnt   <= '0;
                            cmd   <= dec;
                            phase <= dec.valid ? PH_ADDR : PH_IGNORE;
                        end else begin
                            cnt <= cnt + 6'd1;
                        end
                    end
                    PH_ADDR: begin
                        sh <= {sh[SHW-2:0], si_bit};
                        if (cnt == 6'd31) begin
                            cnt       <= '0;
                            addr_word <= addr_now;
                            addr_load <= 1'b1;
                            phase     <= PH_DUMMY;
                        end else begin
                            cnt <= cnt + 6'd1;
                        end
                    end
                    PH_DUMMY: begin
                        if (cnt == 6'(cmd.dummy_bits) - 6'd1) begin
                            cnt   <= '0;
                            phase <= PH_DATA;
                        end else begin
                            cnt <= cnt + 6'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sfr_addr_seq.sv
module sfr_addr_seq
    import sfr_pkg::*;
#(
    parameter int PAGE_BITS  = 14,
    parameter int BYTE_BITS  = 11,
    parameter int PAGE_BYTES = 1056
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  logic [PAGE_BITS+BYTE_BITS-1:0] start,
    input  wrap_t                          wrap,
    input  logic                           advance,
    output logic [PAGE_BITS-1:0]           page,
    output logic [BYTE_BITS-1:0]           byte_idx
);
    localparam logic [BYTE_BITS-1:0] LAST_BYTE = BYTE_BITS'(PAGE_BYTES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            page     <= '0;
            byte_idx <= '0;
        end else if (load) begin
            byte_idx <= start[BYTE_BITS-1:0];
            page     <= (wrap == WRAP_BUF) ? '0 : start[BYTE_BITS +: PAGE_BITS];
        end else if (advance) begin
            if (byte_idx >= LAST_BYTE) begin
                byte_idx <= '0;
                if (wrap == WRAP_ARRAY) begin
                    page <= page + 1'b1;
                end
            end else begin
                byte_idx <= byte_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfr_out_shift.sv
module sfr_out_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       in_data,
    input  logic       sck_fall,
    input  logic [7:0] mem_data,
    output logic       so,
    output logic       oe,
    output logic       advance
);
    logic [7:0] sreg;
    logic [2:0] bit_no;

    assign so = sreg[7];

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            sreg    <= '0;
            bit_no  <= '0;
            oe      <= 1'b0;
            advance <= 1'b0;
        end else begin
            advance <= 1'b0;
            if (in_data && sck_fall) begin
                bit_no <= bit_no + 3'd1;
                if (bit_no == 3'd0) begin
                    sreg    <= mem_data;
                    oe      <= 1'b1;
                    advance <= 1'b1;
                end else begin
                    sreg <= {sreg[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_flash_read_fe.sv
module spi_flash_read_fe
    import sfr_pkg::*;
#(
    parameter int         PAGE_BITS  = 14,
    parameter int         BYTE_BITS  = 11,
    parameter int         PAGE_BYTES = 1056,
    parameter logic [7:0] CAR_OPCODE = 8'hE8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck,
    input  logic                 cs_n,
    input  logic                 si,
    output logic                 so,
    output logic                 so_oe,
    output logic [1:0]           mem_sel,
    output logic [PAGE_BITS-1:0] mem_page,
    output logic [BYTE_BITS-1:0] mem_byte,
    input  logic [7:0]           mem_data
);
    localparam int ADDR_USED = PAGE_BITS + BYTE_BITS;

    logic sck_q, sck_qq, cs_q, si_q;
    logic sck_rise, sck_fall, active;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= 1'b0;
            sck_qq <= 1'b0;
            cs_q   <= 1'b1;
            si_q   <= 1'b0;
        end else begin
            sck_q  <= sck;
            sck_qq <= sck_q;
            cs_q   <= cs_n;
            si_q   <= si;
        end
    end

    assign sck_rise = sck_q & ~sck_qq;
    assign sck_fall = ~sck_q & sck_qq;
    assign active   = ~cs_q;

    phase_t               phase;
    cmd_t                 cmd;
    wrap_t                cmd_wrap;
    logic [ADDR_USED-1:0] addr_word;
    logic                 addr_load;
    logic                 advance;
    logic                 oe_r;

    assign cmd_wrap = cmd.wrap;

    sfr_cmd_parser #(
        .ADDR_USED (ADDR_USED),
        .CAR_OPCODE(CAR_OPCODE)
    ) u_parser (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .sck_rise (sck_rise),
        .si_bit   (si_q),
        .phase    (phase),
        .cmd      (cmd),
        .addr_word(addr_word),
        .addr_load(addr_load)
    );

    sfr_addr_seq #(
        .PAGE_BITS (PAGE_BITS),
        .BYTE_BITS (BYTE_BITS),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .load    (addr_load),
        .start   (addr_word),
        .wrap    (cmd_wrap),
        .advance (advance),
        .page    (mem_page),
        .byte_idx(mem_byte)
    );

    sfr_out_shift u_out (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .in_data (phase == PH_DATA),
        .sck_fall(sck_fall),
        .mem_data(mem_data),
        .so      (so),
        .oe      (oe_r),
        .advance (advance)
    );

    assign so_oe   = oe_r & active;
    assign mem_sel = cmd.src;
endmodule

// File: rtl/spi_flash_read_fe_chk.sv
module spi_flash_read_fe_chk
    import sfr_pkg::*;
#(
    parameter int PAGE_BITS = 14,
    parameter int BYTE_BITS = 11
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cs_n,
    input logic                 so,
    input logic                 so_oe,
    input logic                 sck_fall,
    input logic                 advance,
    input phase_t               phase,
    input wrap_t                wrap,
    input logic [1:0]           mem_sel,
    input logic [PAGE_BITS-1:0] mem_page,
    input logic [BYTE_BITS-1:0] mem_byte
);
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !so_oe) else $error("so_oe high while deselected"); // R1

    AST_SO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (so_oe && !$past(sck_fall)) |-> $stable(so)) else $error("so changed without falling sck"); // R10

    AST_SRC_STEADY: assert property (@(posedge clk) disable iff (rst)
        (so_oe && $past(so_oe)) |-> $stable(mem_sel)) else $error("source changed in data phase"); // R3

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IGNORE) |-> !so_oe) else $error("output driven after unknown opcode"); // R8

    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
        advance |=> (mem_byte == '0 || mem_byte == $past(mem_byte) + 1'b1)) else $error("byte index jumped"); // R5

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        (advance && wrap != WRAP_ARRAY) |=> $stable(mem_page)) else $error("page moved outside continuous mode"); // R7
endmodule

bind spi_flash_read_fe spi_flash_read_fe_chk #(
    .PAGE_BITS(PAGE_BITS),
    .BYTE_BITS(BYTE_BITS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .so      (so),
    .so_oe   (so_oe),
    .sck_fall(sck_fall),
    .advance (advance),
    .phase   (phase),
    .wrap    (cmd_wrap),
    .mem_sel (mem_sel),
    .mem_page(mem_page),
    .mem_byte(mem_byte)
);

// File: tb/spi_flash_read_fe_test.sv
module spi_flash_read_fe_test;
    localparam int TB_PB   = 2;
    localparam int TB_BB   = 3;
    localparam int TB_NPG  = 4;
    localparam int TB_PGSZ = 6;
    localparam logic [7:0] TB_CAR = 8'hE8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic so, so_oe;
    logic [1:0] mem_sel;
    logic [TB_PB-1:0] mem_page;
    logic [TB_BB-1:0] mem_byte;
    logic [7:0] mem_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign mem_data = 8'({mem_sel, mem_page, mem_byte}) ^ 8'h5A;

    spi_flash_read_fe #(
        .PAGE_BITS (TB_PB),
        .BYTE_BITS (TB_BB),
        .PAGE_BYTES(TB_PGSZ),
        .CAR_OPCODE(TB_CAR)
    ) uut (
        .clk     (clk),
        .rst     (rst),
        .sck     (sck),
        .cs_n    (cs_n),
        .si      (si),
        .so      (so),
        .so_oe   (so_oe),
        .mem_sel (mem_sel),
        .mem_page(mem_page),
        .mem_byte(mem_byte),
        .mem_data(mem_data)
    );

    function automatic logic [7:0] model_byte(input int sel, input int pg, input int by);
        return 8'({sel[1:0], pg[TB_PB-1:0], by[TB_BB-1:0]}) ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic r, output logic o);
        si = b;
        repeat (4) @(negedge clk);
        r = so;
        o = so_oe;
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n, output logic oe_seen);
        logic r, o;
        oe_seen = 1'b0;
        for (int i = n - 1; i >= 0; i--) begin
            spi_bit(v[i], r, o);
            oe_seen |= o;
        end
    endtask

    // op: opcode; abort_bits > 0 raises cs_n that many bits into the byte after nbytes
    task automatic read_cmd(input logic [7:0] op, input int pg, input int by, input int nbytes,
                            input int abort_bits, input string req);
        int sel, dummy, ep, eb;
        bit arr;
        logic [31:0] aw;
        logic oe_seen, r, o, oe_all;
        logic [7:0] got;
        sel   = (op == 8'hD4) ? 1 : (op == 8'hD6) ? 2 : 0;
        dummy = (sel == 0) ? 24 : 8;
        arr   = (op == TB_CAR);
        ep    = (sel == 0) ? pg : 0;
        eb    = by;
        aw    = '1;
        aw[TB_BB+TB_PB-1:0] = {pg[TB_PB-1:0], by[TB_BB-1:0]};
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        send_bits(32'(op), 8, oe_seen);
        send_bits(aw, 32, o);
        oe_seen |= o;
        send_bits(32'd0, dummy, o);
        oe_seen |= o;
        check(!oe_seen, "R10 oe low before data", int'(oe_seen), 0);
        for (int k = 0; k < nbytes; k++) begin
            got = '0;
            oe_all = 1'b1;
            for (int b = 0; b < 8; b++) begin
                spi_bit(1'b1, r, o);
                got = {got[6:0], r};
                oe_all &= o;
            end
            check(got == model_byte(sel, ep, eb) && oe_all, req, int'(got), int'(model_byte(sel, ep, eb)));
            if (eb >= TB_PGSZ - 1) begin
                eb = 0;
                if (arr) ep = (ep + 1) % TB_NPG;
            end else begin
                eb = eb + 1;
            end
        end
        for (int b = 0; b < abort_bits; b++) spi_bit(1'b0, r, o);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        if (abort_bits > 0) check(so_oe == 1'b0, "R9 abort drops oe", int'(so_oe), 0);
        else check(so_oe == 1'b0, "R1 oe low after deselect", int'(so_oe), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic bad_cmd(input logic [7:0] op);
        logic oe_seen, o;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        send_bits(32'(op), 8, oe_seen);
        send_bits(32'hFFFF_FFFF, 32, o);
        oe_seen |= o;
        send_bits(32'h00FF_00FF, 32, o);
        oe_seen |= o;
        check(!oe_seen, "R8 unknown opcode silent", int'(oe_seen), 0);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(so_oe == 1'b0, "R1 reset state", int'(so_oe), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(so_oe == 1'b0, "R1 idle after reset", int'(so_oe), 0);

        // R2 and R5: page reads from every start page and byte, crossing the page end
        for (int p = 0; p < TB_NPG; p++)
            for (int b = 0; b < TB_PGSZ; b++)
                read_cmd(8'hD2, p, b, TB_PGSZ + 2, 0, "R2/R5 page read");

        // R4 and R6: continuous reads crossing page ends and the array end
        read_cmd(TB_CAR, 3, 4, 10, 0, "R4/R6 continuous wrap to page 0");
        read_cmd(TB_CAR, 0, 0, 14, 0, "R4/R6 continuous from start");
        read_cmd(TB_CAR, 1, 5, 8, 0, "R4/R6 continuous last byte start");

        // R3 and R7: both buffers from every start byte
        for (int b = 0; b < TB_PGSZ; b++) begin
            read_cmd(8'hD4, 2, b, TB_PGSZ + 2, 0, "R3/R7 buffer 1 read");
            read_cmd(8'hD6, 1, b, TB_PGSZ + 2, 0, "R3/R7 buffer 2 read");
        end

        // R9: mid-byte aborts, each followed by a fresh command
        read_cmd(8'hD2, 1, 2, 2, 3, "R9 data before abort");
        read_cmd(8'hD6, 0, 3, 1, 5, "R9 data before abort");
        read_cmd(8'hD4, 0, 1, 3, 0, "R9 command after abort");

        // R8: unknown opcodes, then a valid one
        bad_cmd(8'h0B);
        bad_cmd(8'hD3);
        bad_cmd(8'h00);
        read_cmd(8'hD2, 2, 1, 3, 0, "R8 command after unknown opcode");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule